// File: doc/BRIEF.md
# Debug Clock Observation Selector

This block steers one of several unrelated internal clocks onto a single debug output so that it can be seen with a probe. A small register, written from a bus clock domain through an APB-style write access, holds the index of the clock to observe. Reading the same register returns the stored index and a flag that shows whether a change of source is still under way.

Each source clock has its own gating cell. The enable for a source is carried into that source's clock domain through two flops. It is then applied on the falling edge of that clock, so the gate only opens or closes while the clock is low. The gated clocks are combined with an OR. A change of index always closes the old gate first and waits until the bus domain sees it closed. Only then does it open the new gate. Because of this, the output never shows merged, shortened or split pulses. An index past the last connected source leaves every gate closed.

Top module: `dbg_clk_sel`

## Requirements
- R1: A bus access with `psel_i`, `penable_i` and `pwrite_i` all high at a rising `clk_i` edge stores `pwdata_i` as the index. `prdata_o[IDX_W-1:0]` always shows the stored index.
- R2: After reset the index reads 0 and `dbg_clk_o` is low. Source 0 is then routed through the normal switching sequence, which ends with the busy flag clearing.
- R3: The busy flag `prdata_o[IDX_W]` is high from the first cycle after a write that changes the index. It stays high until the newly selected source is routed, and then it clears by itself within a bounded time.
- R4: With the busy flag low and an index from 0 to N_SRC-1, `dbg_clk_o` follows the selected source clock exactly.
- R5: No two source gates are ever open at the same time. Every high pulse on `dbg_clk_o` is one complete high phase of a single source.
- R6: `dbg_clk_o` never shows a runt. Every low interval is at least as long as the shortest source low phase.
- R7: An index greater than N_SRC-1 opens no gate. Once the busy flag clears, `dbg_clk_o` stays low.
- R8: Writing the index already stored starts no switch. The busy flag stays low and the output continues without interruption.
- R9: A write that arrives while a switch is in progress is acted on once that switch completes. The final routed source is the last index written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock for the register and the switch sequencer |
| rst_ni | input | 1 | Asynchronous active-low reset for all domains |
| psel_i | input | 1 | Register access select |
| penable_i | input | 1 | Access phase of a register transfer |
| pwrite_i | input | 1 | High for a write transfer |
| pwdata_i | input | IDX_W | Index to store |
| prdata_o | output | IDX_W+1 | Bit IDX_W: busy flag; lower bits: stored index |
| src_clk_i | input | N_SRC | Clocks that can be observed |
| dbg_clk_o | output | 1 | Selected clock, or low |

## Verification
The sources run at six different half periods, each a whole number of nanoseconds and unrelated to the bus clock. Because every half period is different, a pulse width on the output identifies its source, and a pulse made from two sources or a cut-off phase shows up as a width outside the set.

The selection is moved through several patterns:
- steps between fast and slow sources, which stretch the handoff to different lengths;
- a rewrite of the current index, which must leave the output untouched;
- two out-of-range indices, which must silence the output;
- a back-to-back pair of writes, which checks that the last write wins.

Between switches, a reference model compares the output against the expected source on every bus cycle.

// File: rtl/dbg_clk_pkg.sv
package dbg_clk_pkg;
  typedef enum logic [1:0] {
    SW_IDLE,
    SW_DROP,
    SW_RAISE
  } sw_state_e;
endpackage

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic src_clk_i,
  input  logic bus_clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  output logic gclk_o,
  output logic ack_o
);
  logic s1_q, s2_q, gate_q, a1_q, a2_q;

  // enable into the source domain
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= en_req_i;
      s2_q <= s1_q;
    end
  end

  // gate moves only while the source clock is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= s2_q;
  end

  assign gclk_o = src_clk_i & gate_q;

  // gate state back to the bus domain
  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q <= 1'b0;
      a2_q <= 1'b0;
    end else begin
      a1_q <= gate_q;
      a2_q <= a1_q;
    end
  end

  assign ack_o = a2_q;
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import dbg_clk_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic [N_SRC-1:0] req_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SRC - 1);

  sw_state_e        state_q;
  logic [IDX_W-1:0] idx_q, cur_q;
  logic [N_SRC-1:0] req_q, req_nxt;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) req_nxt[i] = (idx_q == IDX_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_DROP;
      idx_q   <= '0;
      cur_q   <= '0;
      req_q   <= '0;
    end else begin
      if (wr_en_i) idx_q <= wr_idx_i;
      unique case (state_q)
        SW_IDLE: begin
          if (idx_q != cur_q) begin
            req_q   <= '0;
            state_q <= SW_DROP;
          end
        end
        SW_DROP: begin
          // break before make: all gates seen closed
          if (ack_i == '0) begin
            cur_q   <= idx_q;
            req_q   <= req_nxt;
            state_q <= (idx_q <= LAST_IDX) ? SW_RAISE : SW_IDLE;
          end
        end
        SW_RAISE: begin
          if (|(ack_i & req_q)) state_q <= SW_IDLE;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = (state_q != SW_IDLE) || (idx_q != cur_q);
  assign req_o  = req_q;

  assert_onehot_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_q));

  assert_make_after_break_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != '0 && $past(req_q) == '0) |-> $past(ack_i) == '0);

  assert_oor_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && idx_q > LAST_IDX) |-> ack_i == '0);

  assert_busy_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i != idx_q && state_q == SW_IDLE) |=> busy_o);
endmodule

// File: rtl/dbg_clk_sel.sv
module dbg_clk_sel #(
  parameter int N_SRC = 6,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psel_i,
  input  logic             penable_i,
  input  logic             pwrite_i,
  input  logic [IDX_W-1:0] pwdata_i,
  output logic [IDX_W:0]   prdata_o,
  input  logic [N_SRC-1:0] src_clk_i,
  output logic             dbg_clk_o
);
  logic             wr_en;
  logic [IDX_W-1:0] idx_w;
  logic             busy_w;
  logic [N_SRC-1:0] req_w, ack_w, gclk_w;

  assign wr_en = psel_i & penable_i & pwrite_i;

  sel_ctrl #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (pwdata_i),
    .ack_i    (ack_w),
    .idx_o    (idx_w),
    .busy_o   (busy_w),
    .req_o    (req_w)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_cell
    clk_gate_cell u_cell (
      .src_clk_i (src_clk_i[g]),
      .bus_clk_i (clk_i),
      .rst_ni    (rst_ni),
      .en_req_i  (req_w[g]),
      .gclk_o    (gclk_w[g]),
      .ack_o     (ack_w[g])
    );
  end

  assign dbg_clk_o = |gclk_w;
  assign prdata_o  = {busy_w, idx_w};

  assert_single_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_w));
endmodule

// File: tb/dbg_clk_sel_test.sv
module dbg_clk_sel_test;
  localparam int N = 6;
  localparam int W = 4;
  localparam int HP [0:5] = '{3000, 4000, 6000, 7000, 9000, 11000};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [W-1:0] pwdata = '0;
  logic [W:0]   prdata;
  logic [N-1:0] src = '0;
  logic         dbg;

  int  n_chk = 0, n_fail = 0, cyc = 0;
  int  exp_idx = 0;
  bit  exp_settled = 1'b0;
  bit  run = 1'b0;
  bit  have_rise = 1'b0, have_fall = 1'b0;
  longint t_rise = 0, t_fall = 0;

  dbg_clk_sel #(.N_SRC(N), .IDX_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .pwdata_i(pwdata), .prdata_o(prdata),
    .src_clk_i(src), .dbg_clk_o(dbg)
  );

  always #2500 clk = ~clk;
  for (genvar g = 0; g < N; g++) begin : g_src
    always #(HP[g]) src[g] = ~src[g];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_hp(longint w);
    for (int i = 0; i < N; i++) if (w == longint'(HP[i])) return 1'b1;
    return 1'b0;
  endfunction

  // reference model, compared every bus cycle
  always @(negedge clk) begin
    #250;
    if (run) begin
      chk(int'(prdata[W-1:0]) == exp_idx, "R1", prdata[W-1:0], exp_idx);
      if (exp_settled) begin
        if (exp_idx < N) chk(dbg == src[exp_idx], "R4", dbg, src[exp_idx]);
        else             chk(dbg == 1'b0, "R7", dbg, 0);
      end
    end
  end

  // pulse shape: one full source phase per high pulse, no short lows
  always @(posedge dbg) begin
    if (run && have_fall) chk(($time - t_fall) >= 3000, "R6", $time - t_fall, 3000);
    t_rise = $time;
    have_rise = 1'b1;
  end
  always @(negedge dbg) begin
    if (run && have_rise) chk(is_hp($time - t_rise), "R5 R6", $time - t_rise, HP[0]);
    t_fall = $time;
    have_fall = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic apb_wr(input int v);
    int prev;
    @(negedge clk);
    if (v != exp_idx) exp_settled = 1'b0;
    psel = 1'b1; pwrite = 1'b1; pwdata = W'(v);
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    prev = exp_idx;
    exp_idx = v;
    #250;
    chk(int'(prdata[W-1:0]) == v, "R1", prdata[W-1:0], v);
    if (v != prev) chk(prdata[W] == 1'b1, "R3", prdata[W], 1);
  endtask

  task automatic settle();
    bit done = 1'b0;
    for (int i = 0; i < 400 && !done; i++) begin
      @(negedge clk);
      #250;
      if (!prdata[W]) done = 1'b1;
    end
    chk(done, "R3", prdata[W], 0);
    exp_settled = 1'b1;
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    #250;
    chk(prdata[W-1:0] == '0, "R2", prdata[W-1:0], 0);
    chk(prdata[W] == 1'b1, "R2", prdata[W], 1);
    chk(dbg == 1'b0, "R2", dbg, 0);
    run = 1'b1;
    settle();                       // R2: source 0 comes up
    repeat (50) @(negedge clk);

    apb_wr(3); settle(); repeat (60) @(negedge clk);

    apb_wr(3);                      // R8: same index
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #250;
      chk(prdata[W] == 1'b0, "R8", prdata[W], 0);
    end

    apb_wr(9);  settle(); repeat (60) @(negedge clk);   // R7
    apb_wr(15); settle(); repeat (40) @(negedge clk);   // R7
    apb_wr(1);  settle(); repeat (50) @(negedge clk);
    apb_wr(5);  settle(); repeat (60) @(negedge clk);
    apb_wr(0);  settle(); repeat (50) @(negedge clk);

    apb_wr(2); apb_wr(4);           // R9: second write mid-switch
    settle();
    chk(int'(prdata[W-1:0]) == 4, "R9", prdata[W-1:0], 4);
    repeat (80) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule